// File: doc/BRIEF.md
# Accumulator Processor Control Unit

This block is the sequencing controller of a small accumulator machine with a 16-bit instruction word. The top two bits of the word choose one of four operations: load, store, add, and branch when the accumulator is negative. The low fourteen bits hold an operand address. The controller steps through a fixed instruction-fetch phase, a decode step and a short execute sequence for each operation. It uses sixteen states in a dense 4-bit binary code.

Every output is a register-transfer enable or a memory strobe, and each one depends only on the current state. A datapath built around this block applies each enable at the clock edge that ends the state. The enables cover clearing, incrementing and loading the program counter, loading the memory address register, filling the memory buffer register, loading the instruction register and updating the accumulator.

Memory accesses pace themselves on a wait handshake. The raw reset and the raw wait each pass through one flip-flop before the state logic sees them, so the controller reacts to both one cycle late.

Top module: `acc_ctrl`

## Requirements
- R1: `state_o` shows the current state in this fixed code: reset 0, fetch-address 1, fetch-request 2, fetch-data 3, fetch-to-IR 4, decode 5, load-address 6, load-read 7, load-to-AC 8, store-address 9, store-write 10, add-address 11, add-read 12, add-sum 13, branch-test 14, branch-jump 15.
- R2: In state 0 only `pc_clr` is asserted, and the next state is always 1 (unless reset is active).
- R3: In state 1, `pc_to_mar` and `pc_inc` are asserted together, and the next state is 2.
- R4: State 2 stays in place until the synchronized wait is 1, then moves to 3. State 3 stays in place while the synchronized wait is 1, then moves to 4. Both states assert `mem_req` and `mem_rd`.
- R5: `mbr_from_mem` is asserted in every cycle of states 3, 7 and 12. State 4 asserts `ir_from_mbr` and moves to 5.
- R6: State 5 dispatches on `op_bits`: 00 goes to 6, 01 to 9, 10 to 11, and 11 to 14. It asserts no output.
- R7: States 6, 9 and 11 assert `mar_from_ir`. State 7 asserts `mem_req` and `mem_rd` and stays until the synchronized wait is 1, then moves to 8. State 8 asserts `acc_from_mbr` and moves to 1.
- R8: State 9 also asserts `mbr_from_acc`. State 10 asserts `mem_req` with `mem_rd` low and stays until the synchronized wait is 1, then moves to 1. No other state requests with `mem_rd` low.
- R9: State 12 requests a read and stays until the synchronized wait is 1, then moves to 13. State 13 asserts `acc_add_mbr` and moves to 1.
- R10: State 14 moves to 1 when `acc_sign` is 0 and to 15 when it is 1. State 15 asserts `pc_from_ir` and moves to 1.
- R11: `rst_in` and `wait_in` each pass through one register. A 1 on `rst_in` sampled at one edge forces state 0 at the following edge.
- R12: Every enable and strobe is a function of the state alone, and every enable not named for a state is 0 in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_in | input | 1 | Raw synchronous reset, active high |
| wait_in | input | 1 | Raw memory wait handshake |
| op_bits | input | 2 | Instruction register bits 15:14 |
| acc_sign | input | 1 | Accumulator bit 15 |
| state_o | output | 4 | Current state code |
| pc_clr | output | 1 | Clear PC to zero |
| pc_inc | output | 1 | Increment PC |
| pc_to_mar | output | 1 | Load MAR from PC |
| pc_from_ir | output | 1 | Load PC from IR[13:0] |
| mar_from_ir | output | 1 | Load MAR from IR[13:0] |
| mbr_from_mem | output | 1 | Load MBR from the memory data bus |
| mbr_from_acc | output | 1 | Load MBR from AC |
| ir_from_mbr | output | 1 | Load IR from MBR |
| acc_from_mbr | output | 1 | Load AC from MBR |
| acc_add_mbr | output | 1 | Load AC with AC plus MBR |
| mem_req | output | 1 | Memory request strobe |
| mem_rd | output | 1 | 1 for read, 0 for write |

## Verification
The bench goes after the wait handshake by drawing random latency and acknowledge lengths. A fetch that leaves state 3 while wait is still high, or leaves state 2 without seeing wait, would capture stale data and end in the wrong accumulator value. The program includes a branch that is taken on a negative accumulator and one that is skipped on a positive accumulator. It also includes a store that must be jumped over, so a swapped dispatch code or an inverted sign test leaves a visible mark in memory. A reset pulse in the middle of the run checks the one-cycle synchronizer delay: a design that reacts at once, or two cycles late, would differ from the per-cycle model.

// File: rtl/acc_ctrl.sv
module acc_ctrl (
  input  logic       clk,
  input  logic       rst_in,
  input  logic       wait_in,
  input  logic [1:0] op_bits,
  input  logic       acc_sign,
  output logic [3:0] state_o,
  output logic       pc_clr,
  output logic       pc_inc,
  output logic       pc_to_mar,
  output logic       pc_from_ir,
  output logic       mar_from_ir,
  output logic       mbr_from_mem,
  output logic       mbr_from_acc,
  output logic       ir_from_mbr,
  output logic       acc_from_mbr,
  output logic       acc_add_mbr,
  output logic       mem_req,
  output logic       mem_rd
);

  typedef enum logic [3:0] {
    S_RST  = 4'd0,  S_FPC  = 4'd1,  S_FREQ = 4'd2,  S_FDAT = 4'd3,
    S_FIR  = 4'd4,  S_DEC  = 4'd5,  S_LADR = 4'd6,  S_LRD  = 4'd7,
    S_LACC = 4'd8,  S_SADR = 4'd9,  S_SWR  = 4'd10, S_AADR = 4'd11,
    S_ARD  = 4'd12, S_ASUM = 4'd13, S_BTST = 4'd14, S_BJMP = 4'd15
  } st_t;

  logic rst_q, wait_q;
  st_t  cur, nxt;

  always_ff @(posedge clk) begin
    rst_q  <= rst_in;
    wait_q <= wait_in;
  end

  always_ff @(posedge clk)
    cur <= rst_q ? S_RST : nxt;

  always_comb begin
    nxt = cur;
    case (cur)
      S_RST:  nxt = S_FPC;
      S_FPC:  nxt = S_FREQ;
      S_FREQ: if (wait_q)  nxt = S_FDAT;
      S_FDAT: if (!wait_q) nxt = S_FIR;
      S_FIR:  nxt = S_DEC;
      S_DEC:
        case (op_bits)
          2'b00:   nxt = S_LADR;
          2'b01:   nxt = S_SADR;
          2'b10:   nxt = S_AADR;
          default: nxt = S_BTST;
        endcase
      S_LADR: nxt = S_LRD;
      S_LRD:  if (wait_q) nxt = S_LACC;
      S_LACC: nxt = S_FPC;
      S_SADR: nxt = S_SWR;
      S_SWR:  if (wait_q) nxt = S_FPC;
      S_AADR: nxt = S_ARD;
      S_ARD:  if (wait_q) nxt = S_ASUM;
      S_ASUM: nxt = S_FPC;
      S_BTST: nxt = acc_sign ? S_BJMP : S_FPC;
      S_BJMP: nxt = S_FPC;
      default: nxt = S_RST;
    endcase
  end

  logic rd_phase;
  assign rd_phase     = (cur == S_FREQ) || (cur == S_FDAT) || (cur == S_LRD) || (cur == S_ARD);

  assign state_o      = cur;
  assign pc_clr       = (cur == S_RST);
  assign pc_inc       = (cur == S_FPC);
  assign pc_to_mar    = (cur == S_FPC);
  assign pc_from_ir   = (cur == S_BJMP);
  assign mar_from_ir  = (cur == S_LADR) || (cur == S_SADR) || (cur == S_AADR);
  assign mbr_from_mem = (cur == S_FDAT) || (cur == S_LRD) || (cur == S_ARD);
  assign mbr_from_acc = (cur == S_SADR);
  assign ir_from_mbr  = (cur == S_FIR);
  assign acc_from_mbr = (cur == S_LACC);
  assign acc_add_mbr  = (cur == S_ASUM);
  assign mem_req      = rd_phase || (cur == S_SWR);
  assign mem_rd       = rd_phase;

  p_reset_r11: assert property (@(posedge clk) rst_q |=> state_o == 4'd0)
    else $error("reset not honoured");
  p_fetch_hold_r4: assert property (@(posedge clk) disable iff (rst_q)
    (state_o == 4'd2 && !wait_q) |=> state_o == 4'd2)
    else $error("fetch request left without wait");
  p_fetch_exit_r4: assert property (@(posedge clk) disable iff (rst_q)
    (state_o == 4'd3 && !wait_q) |=> state_o == 4'd4)
    else $error("fetch data stage did not exit");
  p_dispatch_r6: assert property (@(posedge clk) disable iff (rst_q)
    (state_o == 4'd5 && op_bits == 2'b01) |=> state_o == 4'd9)
    else $error("store dispatch wrong");
  p_branch_r10: assert property (@(posedge clk) disable iff (rst_q)
    (state_o == 4'd14 && !acc_sign) |=> state_o == 4'd1)
    else $error("untaken branch wrong");
  p_write_only_r8: assert property (@(posedge clk) disable iff (rst_q)
    (mem_req && !mem_rd) |-> state_o == 4'd10)
    else $error("write strobe outside store");
  p_enables_r12: assert property (@(posedge clk) disable iff (rst_q)
    $onehot0({pc_clr, pc_inc, pc_from_ir}))
    else $error("conflicting PC enables");

endmodule

// File: tb/acc_ctrl_tb.sv
`timescale 1ns/1ps
module acc_ctrl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_in = 1'b1, wait_in = 1'b0;
  logic [1:0] op_bits;
  logic acc_sign;
  logic [3:0] state_o;
  logic pc_clr, pc_inc, pc_to_mar, pc_from_ir, mar_from_ir, mbr_from_mem;
  logic mbr_from_acc, ir_from_mbr, acc_from_mbr, acc_add_mbr, mem_req, mem_rd;

  acc_ctrl dut_i (.clk(clk), .rst_in(rst_in), .wait_in(wait_in), .op_bits(op_bits),
    .acc_sign(acc_sign), .state_o(state_o), .pc_clr(pc_clr), .pc_inc(pc_inc),
    .pc_to_mar(pc_to_mar), .pc_from_ir(pc_from_ir), .mar_from_ir(mar_from_ir),
    .mbr_from_mem(mbr_from_mem), .mbr_from_acc(mbr_from_acc), .ir_from_mbr(ir_from_mbr),
    .acc_from_mbr(acc_from_mbr), .acc_add_mbr(acc_add_mbr), .mem_req(mem_req), .mem_rd(mem_rd));

  int checks = 0, failures = 0, cyc = 0;
  bit cmp_on = 1'b0;

  logic [15:0] pc, mar, mbr, ir, acc;
  logic [15:0] mem [0:63];
  assign op_bits  = ir[15:14];
  assign acc_sign = acc[15];

  // behavioural datapath
  always @(posedge clk) begin
    if (pc_clr) pc <= 16'd0; else if (pc_inc) pc <= pc + 16'd1;
    else if (pc_from_ir) pc <= {2'b00, ir[13:0]};
    if (pc_to_mar) mar <= pc; else if (mar_from_ir) mar <= {2'b00, ir[13:0]};
    if (mbr_from_mem) mbr <= mem[mar[5:0]]; else if (mbr_from_acc) mbr <= acc;
    if (ir_from_mbr) ir <= mbr;
    if (acc_from_mbr) acc <= mbr; else if (acc_add_mbr) acc <= acc + mbr;
  end

  // memory with random latency and acknowledge length
  int mphase = 0, lat = 0, ackn = 0;
  always @(posedge clk) begin
    if (!mem_req) begin
      mphase <= 0; wait_in <= 1'b0;
    end else begin
      case (mphase)
        0: begin lat <= $urandom_range(0, 3); ackn <= $urandom_range(1, 3); mphase <= 1; end
        1: if (lat == 0) begin
             wait_in <= 1'b1; mphase <= 2;
             if (!mem_rd) mem[mar[5:0]] <= mbr;
           end else lat <= lat - 1;
        2: if (ackn == 1) begin wait_in <= 1'b0; mphase <= 3; end else ackn <= ackn - 1;
        default: ;
      endcase
    end
  end

  // reference sequencer from the state table in the requirements
  logic wd, rd;
  int es = 0;
  always @(posedge clk) begin
    wd <= wait_in; rd <= rst_in;
    if (rd) es <= 0;
    else case (es)
      0: es <= 1;   1: es <= 2;
      2: es <= wd ? 3 : 2;
      3: es <= wd ? 3 : 4;
      4: es <= 5;
      5: es <= (ir[15:14] == 2'b00) ? 6 : (ir[15:14] == 2'b01) ? 9 : (ir[15:14] == 2'b10) ? 11 : 14;
      6: es <= 7;   7: es <= wd ? 8 : 7;   8: es <= 1;
      9: es <= 10;  10: es <= wd ? 1 : 10;
      11: es <= 12; 12: es <= wd ? 13 : 12; 13: es <= 1;
      14: es <= acc[15] ? 15 : 1;
      default: es <= 1;
    endcase
  end

  function automatic logic [11:0] exp_out(int s);
    logic [11:0] v = '0; // pc_clr pc_inc pc_to_mar pc_from_ir mar_from_ir mbr_from_mem mbr_from_acc ir_from_mbr acc_from_mbr acc_add_mbr mem_req mem_rd
    case (s)
      0: v[11] = 1'b1;
      1: begin v[10] = 1'b1; v[9] = 1'b1; end
      2: v[1:0] = 2'b11;
      3: begin v[6] = 1'b1; v[1:0] = 2'b11; end
      4: v[4] = 1'b1;
      6, 11: v[7] = 1'b1;
      7, 12: begin v[6] = 1'b1; v[1:0] = 2'b11; end
      8: v[3] = 1'b1;
      9: begin v[7] = 1'b1; v[5] = 1'b1; end
      10: v[1:0] = 2'b10;
      13: v[2] = 1'b1;
      15: v[8] = 1'b1;
      default: ;
    endcase
    return v;
  endfunction

  function automatic string tag(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2, 3: return "R4"; 4: return "R5"; 5: return "R6";
      6, 7, 8: return "R7"; 9, 10: return "R8"; 11, 12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [11:0] outs;
  assign outs = {pc_clr, pc_inc, pc_to_mar, pc_from_ir, mar_from_ir, mbr_from_mem,
                 mbr_from_acc, ir_from_mbr, acc_from_mbr, acc_add_mbr, mem_req, mem_rd};

  always @(negedge clk) if (cmp_on) begin
    check(state_o == es[3:0], "R1 state", {28'd0, state_o}, es);
    check(outs == exp_out(es), {tag(es), " R12 outputs"}, {20'd0, outs}, {20'd0, exp_out(es)});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [15:0] ins(logic [1:0] op, int a);
    return {op, 14'(a)};
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'd0;
    mem[0] = ins(2'b00, 40); mem[1] = ins(2'b10, 41); mem[2] = ins(2'b01, 42);
    mem[3] = ins(2'b11, 6);  mem[4] = ins(2'b01, 43); mem[5] = ins(2'b01, 43);
    mem[6] = ins(2'b10, 44); mem[7] = ins(2'b01, 45); mem[8] = ins(2'b11, 0);
    mem[9] = ins(2'b00, 45); mem[10] = ins(2'b10, 46); mem[11] = ins(2'b01, 47);
    mem[12] = ins(2'b11, 12);
    mem[40] = 16'd5; mem[41] = 16'hFFF8; mem[43] = 16'h1234; mem[44] = 16'd10; mem[46] = 16'hFFEC;
    acc = 16'd0; ir = 16'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_in = 1'b0;
    check(state_o == 4'd0, "R1 reset state", {28'd0, state_o}, 0);
    cmp_on = 1'b1;
    repeat (900) @(posedge clk);
    @(negedge clk);
    check(acc == 16'hFFF3, "R9 final AC", {16'd0, acc}, 32'hFFF3);
    check(mem[42] == 16'hFFFD, "R8 store after add", {16'd0, mem[42]}, 32'hFFFD);
    check(mem[43] == 16'h1234, "R10 skipped store", {16'd0, mem[43]}, 32'h1234);
    check(mem[45] == 16'd7, "R7 store then load", {16'd0, mem[45]}, 7);
    check(mem[47] == 16'hFFF3, "R8 last store", {16'd0, mem[47]}, 32'hFFF3);
    check(pc == 16'd12 || pc == 16'd13, "R10 taken loop PC", {16'd0, pc}, 13);
    // mid-run reset pulse: seen one edge late
    rst_in = 1'b1;
    @(posedge clk); @(negedge clk);
    rst_in = 1'b0;
    @(posedge clk); @(negedge clk);
    check(state_o == 4'd0, "R11 reset latency", {28'd0, state_o}, 0);
    @(posedge clk); @(negedge clk);
    check(state_o == 4'd1, "R2 leave reset", {28'd0, state_o}, 1);
    check(pc == 16'd0, "R2 PC cleared", {16'd0, pc}, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule